// File: doc/BRIEF.md
# Active Power Computation Datapath

This block turns a pair of signed current and voltage sample streams into a smoothed instantaneous real-power value. Both streams arrive together under one valid strobe. Each stream first passes through a first-order high-pass stage that strips the DC offset. The two high-pass stages are structurally identical and update on the same strobe, so they add no phase error between the channels. A live control input can bypass both high-pass stages at once so that DC power can be measured.

The two filtered samples are multiplied at full precision into an instantaneous power product. A first-order recursive low-pass stage then averages this product to suppress the double-line-frequency ripple. The result is scaled, saturated and presented with its own valid strobe to a downstream pulse generator. Filter coefficients are power-of-two shifts chosen as parameters; the defaults of 9 and 8 give corners near 4.4 Hz and 8.7 Hz at a sample rate of roughly 14 kHz.

A synchronous active-low clear zeroes every state register and forces both input codes to zero for as long as it is held. An asynchronous active-low reset does the same at power-up.

Top module: `real_power_dp`

## Requirements
- R1: After reset, and in every cycle after a clock edge at which `clr_n` was low, `pwr_vld` is 0 and `pwr_out` is 0.
- R2: When `smp_vld` is high at clock edge n and `clr_n` stays high through edge n+2, `pwr_vld` is high for exactly the one cycle after edge n+2. It is low after edges n+1 and n+3 unless other samples cause it.
- R3: With `hpf_en` = 0, each channel's filtered sample equals its input sample, so the product is `cur_smp * volt_smp`. The offset estimators keep updating, so later switching happens without a restart.
- R4: With `hpf_en` = 1, each channel keeps an estimator E (reset 0). On each sample x it forms d = x - (E >>> HP_SHIFT), saturates d to the signed 16-bit range [-32768, 32767] as the filtered value, and updates E to E + x - (E >>> HP_SHIFT). Both channels use identical arithmetic.
- R5: The power product is the exact signed 32-bit product of the two filtered 16-bit samples.
- R6: The low-pass accumulator A (reset 0) updates once per product to A + p - (A >>> LP_SHIFT). The averaged power is A >>> LP_SHIFT, taken after the update.
- R7: `pwr_out` is (averaged power >>> OUT_SHIFT) saturated to the signed OUT_W-bit range. With OUT_W = 24 the limits are 8388607 and -8388608.
- R8: In cycles without a sample strobe, no filter state changes, so `pwr_out` holds its value.
- R9: Samples presented while `clr_n` is low do not affect the state. After the clear is released, the first result equals the one a freshly reset block would give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear of all state |
| hpf_en | input | 1 | 1 enables both high-pass stages, 0 bypasses both |
| smp_vld | input | 1 | Strobe marking a new sample pair |
| cur_smp | input | 16 | Signed current-channel sample |
| volt_smp | input | 16 | Signed voltage-channel sample |
| pwr_vld | output | 1 | Strobe marking a new power result |
| pwr_out | output | OUT_W (24) | Signed averaged power, scaled and saturated |

## Verification
A full grid of corner codes on both channels (both full-scale extremes, ±1, zero, mid-range values), with the high-pass stages bypassed, separates sign and width errors in the product from errors in the averaging recursion. Long runs at positive and negative full-scale power drive the output into both saturation limits. A DC input with the filters enabled shows the offset decaying away. Offset triangle waves in phase and in anti-phase show positive and negative power surviving the filter. A jump from full-scale positive to full-scale negative drives the high-pass difference below the 16-bit range. Toggling `hpf_en` mid-stream, and a clear held while garbage samples are strobed, show that the bypass and the clear act on the live state exactly as specified.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
  localparam int SMP_W = 16;
  localparam int PRD_W = 2 * SMP_W;
  localparam int N_CH  = 2;
  typedef logic signed [SMP_W-1:0] smp_t;
endpackage

// File: rtl/rpw_hp_stage.sv
module rpw_hp_stage #(
  parameter int DW       = rpw_pkg::SMP_W,
  parameter int HP_SHIFT = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_n,
  input  logic                 hpf_en,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] y_q
);
  localparam int EW = DW + HP_SHIFT + 1;
  localparam logic signed [EW-1:0] Y_MAX = {{(HP_SHIFT+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [EW-1:0] Y_MIN = {{(HP_SHIFT+2){1'b1}}, {(DW-1){1'b0}}};

  logic signed [EW-1:0] est_q, est_d, x_w, dc, diff;
  logic signed [DW-1:0] y_d, y_hp;

  always_comb begin
    x_w  = {{(HP_SHIFT+1){x[DW-1]}}, x};
    dc   = est_q >>> HP_SHIFT;
    diff = x_w - dc;
    if (diff > Y_MAX)      y_hp = Y_MAX[DW-1:0];
    else if (diff < Y_MIN) y_hp = Y_MIN[DW-1:0];
    else                   y_hp = diff[DW-1:0];
    est_d = est_q;
    y_d   = y_q;
    if (!clr_n) begin
      est_d = '0;
      y_d   = '0;
    end else if (in_vld) begin
      est_d = est_q + diff;
      y_d   = hpf_en ? y_hp : x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q <= '0;
      y_q   <= '0;
    end else begin
      est_q <= est_d;
      y_q   <= y_d;
    end
  end

  // R3: bypassed stage passes the sample through untouched
  a_r3_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!hpf_en && in_vld && clr_n) |=> (y_q == $past(x)));
endmodule

// File: rtl/rpw_mult.sv
module rpw_mult #(
  parameter int DW = rpw_pkg::SMP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_n,
  input  logic                   in_vld,
  input  logic signed [DW-1:0]   a,
  input  logic signed [DW-1:0]   b,
  output logic signed [2*DW-1:0] p_q
);
  logic signed [2*DW-1:0] p_d;

  always_comb begin
    p_d = p_q;
    if (!clr_n)      p_d = '0;
    else if (in_vld) p_d = a * b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_q <= '0;
    else        p_q <= p_d;
  end

  // R5: registered product is the exact signed product of the operands
  a_r5_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && clr_n) |=> (p_q == $past(a) * $past(b)));
endmodule

// File: rtl/rpw_lp_stage.sv
module rpw_lp_stage #(
  parameter int PW        = rpw_pkg::PRD_W,
  parameter int LP_SHIFT  = 8,
  parameter int OUT_W     = 24,
  parameter int OUT_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_n,
  input  logic                    in_vld,
  input  logic signed [PW-1:0]    p,
  output logic signed [OUT_W-1:0] y
);
  localparam int AW = PW + LP_SHIFT + 1;
  localparam logic signed [AW-1:0] O_MAX = {{(AW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [AW-1:0] O_MIN = {{(AW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [AW-1:0] acc_q, acc_d, p_w, avg, scl;

  always_comb begin
    p_w   = {{(LP_SHIFT+1){p[PW-1]}}, p};
    acc_d = acc_q;
    if (!clr_n)      acc_d = '0;
    else if (in_vld) acc_d = acc_q + p_w - (acc_q >>> LP_SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_comb begin
    avg = acc_q >>> LP_SHIFT;
    scl = avg >>> OUT_SHIFT;
    if (scl > O_MAX)      y = O_MAX[OUT_W-1:0];
    else if (scl < O_MIN) y = O_MIN[OUT_W-1:0];
    else                  y = scl[OUT_W-1:0];
  end

  // R8: accumulator only moves on a product strobe or a clear
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld && clr_n) |=> $stable(acc_q));
endmodule

// File: rtl/real_power_dp.sv
module real_power_dp #(
  parameter int HP_SHIFT  = 9,
  parameter int LP_SHIFT  = 8,
  parameter int OUT_W     = 24,
  parameter int OUT_SHIFT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_n,
  input  logic                         hpf_en,
  input  logic                         smp_vld,
  input  logic signed [rpw_pkg::SMP_W-1:0] cur_smp,
  input  logic signed [rpw_pkg::SMP_W-1:0] volt_smp,
  output logic                         pwr_vld,
  output logic signed [OUT_W-1:0]      pwr_out
);
  import rpw_pkg::*;

  smp_t                     ch_in [N_CH];
  smp_t                     ch_hp [N_CH];
  logic signed [PRD_W-1:0]  prod;
  logic [2:0]               vp_q, vp_d;

  always_comb begin
    ch_in[0] = clr_n ? cur_smp  : '0;
    ch_in[1] = clr_n ? volt_smp : '0;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    rpw_hp_stage #(.DW(SMP_W), .HP_SHIFT(HP_SHIFT)) u_hp (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_n  (clr_n),
      .hpf_en (hpf_en),
      .in_vld (smp_vld),
      .x      (ch_in[c]),
      .y_q    (ch_hp[c])
    );
  end

  rpw_mult #(.DW(SMP_W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_n  (clr_n),
    .in_vld (vp_q[0]),
    .a      (ch_hp[0]),
    .b      (ch_hp[1]),
    .p_q    (prod)
  );

  rpw_lp_stage #(.PW(PRD_W), .LP_SHIFT(LP_SHIFT), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) u_lp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_n  (clr_n),
    .in_vld (vp_q[1]),
    .p      (prod),
    .y      (pwr_out)
  );

  always_comb begin
    vp_d = clr_n ? {vp_q[1:0], smp_vld} : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vp_q <= '0;
    else        vp_q <= vp_d;
  end

  assign pwr_vld = vp_q[2];

  // R1: a clear leaves output and strobe at zero
  a_r1_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (!pwr_vld && pwr_out == '0));

  // R2: a captured sample yields a result strobe two edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && clr_n) ##1 clr_n ##1 clr_n |=> pwr_vld);
endmodule

// File: tb/real_power_dp_tb.sv
module real_power_dp_tb;
  localparam int KH = 3;
  localparam int KL = 2;
  localparam int OW = 24;
  localparam int SH = 4;

  logic clk = 1'b0;
  logic rst_n, clr_n, hpf_en, smp_vld;
  logic signed [15:0] cur_smp, volt_smp;
  logic pwr_vld;
  logic signed [OW-1:0] pwr_out;

  int n_chk = 0;
  int n_bad = 0;

  longint est_i, est_v, acc, expv;

  always #5 clk = ~clk;

  real_power_dp #(.HP_SHIFT(KH), .LP_SHIFT(KL), .OUT_W(OW), .OUT_SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .hpf_en(hpf_en), .smp_vld(smp_vld),
    .cur_smp(cur_smp), .volt_smp(volt_smp), .pwr_vld(pwr_vld), .pwr_out(pwr_out)
  );

  function automatic longint satw(longint v, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    est_i = 0; est_v = 0; acc = 0; expv = 0;
  endtask

  // one sample, inputs set at a falling edge; checks timing, value and hold
  task automatic send(longint ci, longint cv, bit en, string tag);
    longint yi, yv, di, dv, p;
    cur_smp = 16'(ci); volt_smp = 16'(cv); hpf_en = en; smp_vld = 1'b1;
    di = ci - (est_i >>> KH);
    dv = cv - (est_v >>> KH);
    est_i = est_i + di;
    est_v = est_v + dv;
    yi = en ? satw(di, 16) : ci;
    yv = en ? satw(dv, 16) : cv;
    p = yi * yv;
    acc = acc + p - (acc >>> KL);
    expv = satw((acc >>> KL) >>> SH, OW);
    @(negedge clk); smp_vld = 1'b0;
    @(negedge clk); check("R2 strobe low before result", longint'(pwr_vld), 0);
    @(negedge clk); check("R2 strobe on result", longint'(pwr_vld), 1);
    check(tag, longint'(pwr_out), expv);
    @(negedge clk); check("R2 strobe single cycle", longint'(pwr_vld), 0);
    check("R8 hold after result", longint'(pwr_out), expv);
  endtask

  task automatic do_clear();
    clr_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cur_smp = 16'sd12345; volt_smp = -16'sd23456; smp_vld = k[0];
      @(negedge clk);
    end
    smp_vld = 1'b0;
    check("R1 clear output zero", longint'(pwr_out), 0);
    check("R1 clear strobe low", longint'(pwr_vld), 0);
    clr_n = 1'b1;
    model_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    longint vals [9] = '{-32768, -32767, -256, -1, 0, 1, 255, 32766, 32767};
    rst_n = 1'b0; clr_n = 1'b1; hpf_en = 1'b0; smp_vld = 1'b0;
    cur_smp = '0; volt_smp = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset output zero", longint'(pwr_out), 0);
    check("R1 reset strobe low", longint'(pwr_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // bypass grid over corner codes: product and averaging (R3, R5, R6)
    foreach (vals[a]) foreach (vals[b]) send(vals[a], vals[b], 1'b0, "R5 R6 bypass grid");

    // idle gap: nothing moves (R8)
    repeat (10) @(negedge clk);
    check("R8 idle hold", longint'(pwr_out), expv);

    // clear with garbage strobed in (R1, R9)
    do_clear();
    send(100, 200, 1'b1, "R9 first result after clear");

    // positive and negative saturation (R7)
    do_clear();
    for (int k = 0; k < 20; k++) send(32767, 32767, 1'b0, "R7 R3 positive run");
    check("R7 positive limit", longint'(pwr_out), 8388607);
    for (int k = 0; k < 20; k++) send(32767, -32768, 1'b0, "R7 R3 negative run");
    check("R7 negative limit", longint'(pwr_out), -8388608);

    // DC with filters enabled decays (R4)
    do_clear();
    for (int k = 0; k < 40; k++) send(1000, -700, 1'b1, "R4 DC removal");

    // offset triangles in phase and anti-phase (R4, R6)
    do_clear();
    for (int k = 0; k < 64; k++) begin
      int t = (k % 16) < 8 ? (k % 16) * 2000 - 8000 : 24000 - (k % 16) * 2000;
      send(t + 600, t - 300, 1'b1, "R4 R6 in-phase wave");
    end
    for (int k = 0; k < 64; k++) begin
      int t = (k % 16) < 8 ? (k % 16) * 2000 - 8000 : 24000 - (k % 16) * 2000;
      send(t + 600, 300 - t, 1'b1, "R4 R6 anti-phase wave");
    end

    // high-pass difference below 16-bit range saturates (R4)
    do_clear();
    for (int k = 0; k < 12; k++) send(32767, 32767, 1'b1, "R4 full-scale settle");
    send(-32768, -32768, 1'b1, "R4 difference saturation");
    send(-32768, 32767, 1'b1, "R4 difference saturation mixed");

    // live bypass toggling with estimators still tracking (R3)
    for (int k = 0; k < 30; k++) send(5000 - k * 300, 2000 + k * 100, k[1], "R3 live toggle");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule